// File: doc/BRIEF.md
# Strap-Selected Clock Source Controller with Oscillator Watchdog

This block sets how the CPU clock is produced, based on a 3-bit strap value that is captured only while reset is held. There are three sources. The input clock can pass through unchanged. It can be halved. Or it can come from an external frequency multiplier, whose lock state arrives as an input. The block gives the CPU clock as an enable pulse, `cpu_ce`, in the domain of a free-running base oscillator. It also gives a mode code, so that downstream clock muxing can pick the matching source.

The block also acts as an oscillator watchdog, and it runs from the base clock in every mode. The input clock passes through a synchroniser, and its rising edges are counted over a fixed window of base-clock cycles. If the count falls outside a programmable band, or if the multiplier loses lock, the block does three things. It raises a sticky interrupt request, it sets a failure flag, and it moves the CPU onto the base clock so that emergency code can still run. The multiplier may only acquire lock while reset is asserted. A lock-ready status lets board logic keep reset held until lock is reached.

Top module: `clksrc_ctrl`

## Requirements
- R1: `mode` is loaded from `strap` on every base-clock edge while `rst_n` is low, and keeps its value after reset ends, whatever `strap` does later. The strap values map to mode codes as follows: strap 3'b011 gives mode 2'b01 (direct), strap 3'b001 gives mode 2'b10 (halved), and any other strap gives mode 2'b00 (multiplied).
- R2: In direct mode without failure, `cpu_ce` pulses once for each rising edge of `clk_in`. An input of period 8 base cycles gives exactly 8 pulses in any 64-cycle span.
- R3: In halved mode without failure, `cpu_ce` pulses on every second rising edge of `clk_in`. An input of period 8 gives exactly 4 pulses per 64 cycles.
- R4: In multiplied mode, `lock_ok` is high only when two conditions hold: `pll_locked` was high at the last reset cycle, and it is high now. A lock that first appears after reset never makes `lock_ok` high, and it is treated as a loss of lock. While `lock_ok` is high, `cpu_ce` is high on every base cycle.
- R5: The watchdog counts synchronised rising edges of `clk_in` over windows of `WIN_CYCLES` base cycles. At the end of a window, a count below `lo_lim` or above `hi_lim` is a failure event. An input that has stopped, or one that runs far too fast, therefore ends up setting `fail`.
- R6: A failure event, from either the watchdog or the lock, sets `fail`. From then on `cpu_ce` is high on every base cycle, and both `fail` and `cpu_ce` stay high until the next reset, even if the input clock or the lock comes back.
- R7: A failure event sets `irq` in the following cycle. A pulse on `irq_clr` clears `irq`. If an event and a clear arrive in the same cycle, the event wins, and any later event sets `irq` again.
- R8: While reset is held and in the first cycle after it, `irq` and `fail` are low. While reset is held, `cpu_ce` and `lock_ok` are also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Free-running base oscillator clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| strap | input | 3 | Clock-mode strap, captured during reset |
| clk_in | input | 1 | Input (crystal) clock, asynchronous to clk_base |
| pll_locked | input | 1 | Lock indication from the frequency multiplier |
| lo_lim | input | CNT_W | Minimum legal input edges per window |
| hi_lim | input | CNT_W | Maximum legal input edges per window |
| irq_clr | input | 1 | Write-one-to-clear strobe for irq |
| mode | output | 2 | Selected mode: 00 multiplied, 01 direct, 10 halved |
| cpu_ce | output | 1 | CPU clock enable in the base domain |
| lock_ok | output | 1 | Multiplier locked and usable |
| fail | output | 1 | Sticky fallback to the base clock |
| irq | output | 1 | Sticky clock-failure interrupt request |

## Verification
A halving toggle left in the wrong phase, or a mode register that picks up strap changes after reset, appears at once in the number of `cpu_ce` pulses over a whole number of input periods. Checking a full 64-cycle span is therefore enough to expose it. A watchdog counter that is off by one, or a comparison that is off by one, is only visible at the end of a window. Because of that, checks of `fail` and `irq` wait for up to two windows after the input clock stops or speeds up. A fallback or lock flag that is not sticky shows at the ports as soon as the clock or the lock comes back, so the bench restores both inputs and then samples again.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

   typedef enum logic [1:0] {
      CSM_MULT   = 2'b00,
      CSM_DIRECT = 2'b01,
      CSM_HALF   = 2'b10
   } csm_mode_e;

   function automatic csm_mode_e strap_to_mode(input logic [2:0] s);
      case (s)
         3'b011:  return CSM_DIRECT;
         3'b001:  return CSM_HALF;
         default: return CSM_MULT;
      endcase
   endfunction

endpackage

// File: rtl/clksrc_sync.sv
module clksrc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clksrc_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/clksrc_wdog.sv
module clksrc_wdog #(
   parameter int WIN_CYCLES = 64,
   parameter int CNT_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  logic [CNT_W-1:0] lo_lim,
   input  logic [CNT_W-1:0] hi_lim,
   output logic             bad_o
);
   localparam int WIN_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
   localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

   logic [WIN_W-1:0] win_q;
   logic [CNT_W-1:0] edges_q;
   logic [CNT_W:0]   total;
   logic             win_end;

   generate
      if (WIN_CYCLES < 2) begin : g_bad_win
         $error("clksrc_wdog window must be at least two cycles");
      end
   endgenerate

   assign win_end = (win_q == WIN_LAST);
   assign total   = {1'b0, edges_q} + {{CNT_W{1'b0}}, rise_i};
   assign bad_o   = win_end &&
                    ((total < {1'b0, lo_lim}) || (total > {1'b0, hi_lim}));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q   <= '0;
         edges_q <= '0;
      end else if (win_end) begin
         win_q   <= '0;
         edges_q <= '0;
      end else begin
         win_q <= win_q + 1'b1;
         if (rise_i && (edges_q != {CNT_W{1'b1}}))
            edges_q <= edges_q + 1'b1;
      end
   end
endmodule

// File: rtl/clksrc_guard.sv
module clksrc_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_bad_i,
   input  logic wd_bad_i,
   input  logic irq_clr_i,
   output logic fail_o,
   output logic irq_o
);
   logic lock_bad_q;
   logic event_w;

   assign event_w = wd_bad_i | (lock_bad_i & ~lock_bad_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_bad_q <= 1'b0;
         fail_o     <= 1'b0;
         irq_o      <= 1'b0;
      end else begin
         lock_bad_q <= lock_bad_i;
         if (event_w) fail_o <= 1'b1;
         irq_o <= (irq_o & ~irq_clr_i) | event_w;
      end
   end
endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
   import clksrc_pkg::*;
#(
   parameter int WIN_CYCLES  = 64,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_base,
   input  logic             rst_n,
   input  logic [2:0]       strap,
   input  logic             clk_in,
   input  logic             pll_locked,
   input  logic [CNT_W-1:0] lo_lim,
   input  logic [CNT_W-1:0] hi_lim,
   input  logic             irq_clr,
   output logic [1:0]       mode,
   output logic             cpu_ce,
   output logic             lock_ok,
   output logic             fail,
   output logic             irq
);
   csm_mode_e mode_q;
   logic      run_q;
   logic      acq_q;
   logic      half_q;
   logic      in_rise;
   logic      wd_bad;
   logic      lock_good;
   logic      lock_bad;
   logic      src_ce;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("clksrc_ctrl edge counter too narrow");
      end
   endgenerate

   always_ff @(posedge clk_base) begin
      if (!rst_n) begin
         mode_q <= strap_to_mode(strap);
         acq_q  <= pll_locked;
         run_q  <= 1'b0;
         half_q <= 1'b0;
      end else begin
         run_q <= 1'b1;
         if (in_rise && (mode_q == CSM_HALF)) half_q <= ~half_q;
      end
   end

   clksrc_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk_base),
      .rst_n   (rst_n),
      .async_i (clk_in),
      .rise_o  (in_rise)
   );

   clksrc_wdog #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) wdog_i (
      .clk    (clk_base),
      .rst_n  (rst_n),
      .rise_i (in_rise),
      .lo_lim (lo_lim),
      .hi_lim (hi_lim),
      .bad_o  (wd_bad)
   );

   assign lock_good = (mode_q == CSM_MULT) && acq_q && pll_locked;
   assign lock_bad  = run_q && (mode_q == CSM_MULT) && !(acq_q && pll_locked);

   clksrc_guard guard_i (
      .clk        (clk_base),
      .rst_n      (rst_n),
      .lock_bad_i (lock_bad),
      .wd_bad_i   (wd_bad),
      .irq_clr_i  (irq_clr),
      .fail_o     (fail),
      .irq_o      (irq)
   );

   always_comb begin
      case (mode_q)
         CSM_DIRECT: src_ce = in_rise;
         CSM_HALF:   src_ce = in_rise & half_q;
         default:    src_ce = lock_good;
      endcase
   end

   assign mode    = mode_q;
   assign cpu_ce  = run_q & (fail | src_ce);
   assign lock_ok = run_q & ~fail & lock_good;
endmodule

// File: rtl/clksrc_ctrl_chk.sv
module clksrc_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode,
   input logic       cpu_ce,
   input logic       lock_ok,
   input logic       pll_locked,
   input logic       fail,
   input logic       irq
);
   // R1: mode frozen once reset has ended
   a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(mode));

   // R3: halved mode never gives two pulses back to back
   a_r3_half_spaced: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && !fail && cpu_ce) |=> (fail || !cpu_ce));

   // R4: lock status only in multiplied mode with live lock
   a_r4_lock_valid: assert property (@(posedge clk) disable iff (!rst_n)
      lock_ok |-> (pll_locked && mode == 2'b00 && !fail));

   // R6: fallback is sticky and drives the enable every cycle
   a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> fail);
   a_r6_fallback_ce: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> cpu_ce);

   // R7: entering failure always raises the request
   a_r7_irq_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> irq);
endmodule

bind clksrc_ctrl clksrc_ctrl_chk chk_i (
   .clk        (clk_base),
   .rst_n      (rst_n),
   .mode       (mode),
   .cpu_ce     (cpu_ce),
   .lock_ok    (lock_ok),
   .pll_locked (pll_locked),
   .fail       (fail),
   .irq        (irq)
);

// File: tb/clksrc_ctrl_tb_top.sv
module clksrc_ctrl_tb_top;
   localparam int CW = 8;

   logic          clk_base = 1'b0;
   logic          rst_n    = 1'b0;
   logic [2:0]    strap    = 3'b000;
   logic          clk_in   = 1'b0;
   logic          pll_locked = 1'b0;
   logic [CW-1:0] lo_lim   = 8'd4;
   logic [CW-1:0] hi_lim   = 8'd12;
   logic          irq_clr  = 1'b0;
   logic [1:0]    mode;
   logic          cpu_ce, lock_ok, fail, irq;

   int checks = 0;
   int errors = 0;
   int hp     = 4;
   int ph     = 0;

   typedef struct { string tag; int val; } exp_t;
   exp_t sb_q[$];

   clksrc_ctrl dut_i (
      .clk_base(clk_base), .rst_n(rst_n), .strap(strap), .clk_in(clk_in),
      .pll_locked(pll_locked), .lo_lim(lo_lim), .hi_lim(hi_lim),
      .irq_clr(irq_clr), .mode(mode), .cpu_ce(cpu_ce), .lock_ok(lock_ok),
      .fail(fail), .irq(irq)
   );

   always #5 clk_base = ~clk_base;

   // input clock generator: toggles every hp base cycles, stopped when hp==0
   always @(negedge clk_base) begin
      if (hp != 0) begin
         if (ph >= hp - 1) begin ph = 0; clk_in = ~clk_in; end
         else ph = ph + 1;
      end
   end

   // driver side: push expectation
   task automatic expect_val(input string tag, input int val);
      sb_q.push_back('{tag, val});
   endtask

   // monitor side: pop and compare with observed value
   task automatic observe(input int act);
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (act != e.val) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", e.tag, act, e.val);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk_base);
   endtask

   task automatic count_ce(input int n, output int c);
      c = 0;
      repeat (n) begin @(negedge clk_base); if (cpu_ce) c++; end
   endtask

   task automatic do_reset(input logic [2:0] s, input logic lk);
      @(negedge clk_base);
      rst_n = 1'b0; strap = s; pll_locked = lk;
      cyc(6);
      rst_n = 1'b1;
   endtask

   initial begin
      int c;
      // ---- R8 reset state, R1 decode of 011 ----
      do_reset(3'b011, 1'b0);
      // sample while reset was still low is done below with a fresh reset
      @(negedge clk_base); rst_n = 1'b0; cyc(3);
      expect_val("R8 irq in reset", 0);      observe(irq);
      expect_val("R8 fail in reset", 0);     observe(fail);
      expect_val("R8 ce in reset", 0);       observe(cpu_ce);
      expect_val("R8 lock_ok in reset", 0);  observe(lock_ok);
      expect_val("R1 strap 011 -> 01", 1);   observe(mode);
      rst_n = 1'b1; cyc(1);
      expect_val("R8 fail after reset", 0);  observe(fail);

      // ---- R2 direct pass-through ----
      cyc(8);
      count_ce(64, c);
      expect_val("R2 direct pulses/64", 8);  observe(c);
      strap = 3'b001; cyc(4);
      expect_val("R1 strap ignored after reset", 1); observe(mode);
      cyc(70);
      expect_val("R5 in-band input no fail", 0); observe(fail);

      // ---- R3 halved ----
      do_reset(3'b001, 1'b0);
      cyc(2);
      expect_val("R1 strap 001 -> 10", 2);   observe(mode);
      cyc(6);
      count_ce(64, c);
      expect_val("R3 halved pulses/64", 4);  observe(c);
      count_ce(64, c);
      expect_val("R3 halved pulses second span", 4); observe(c);

      // ---- R5/R6/R7 input clock stops ----
      hp = 0;
      cyc(140);
      expect_val("R5 stopped input fail", 1); observe(fail);
      expect_val("R7 irq on stopped input", 1); observe(irq);
      count_ce(64, c);
      expect_val("R6 fallback ce/64", 64);   observe(c);
      hp = 4; cyc(150);
      expect_val("R6 fail sticky after input returns", 1); observe(fail);

      // ---- R5 too fast input ----
      do_reset(3'b011, 1'b0);
      hp = 1;
      cyc(140);
      expect_val("R5 fast input fail", 1);   observe(fail);
      hp = 4;

      // ---- R4 multiplied mode with lock during reset ----
      do_reset(3'b000, 1'b1);
      cyc(2);
      expect_val("R1 strap 000 -> 00", 0);   observe(mode);
      expect_val("R4 lock_ok after reset", 1); observe(lock_ok);
      count_ce(64, c);
      expect_val("R4 locked ce/64", 64);     observe(c);
      expect_val("R7 no irq while locked", 0); observe(irq);
      pll_locked = 1'b0; cyc(1);
      expect_val("R4 lock_ok drops", 0);     observe(lock_ok);
      cyc(2);
      expect_val("R6 fail on unlock", 1);    observe(fail);
      expect_val("R7 irq on unlock", 1);     observe(irq);
      pll_locked = 1'b1; cyc(3);
      expect_val("R6 lock_ok stays low after relock", 0); observe(lock_ok);
      // R7 clear then new event
      irq_clr = 1'b1; cyc(1); irq_clr = 1'b0; cyc(1);
      expect_val("R7 irq cleared", 0);       observe(irq);
      cyc(100);
      expect_val("R7 irq stays clear without event", 0); observe(irq);
      hp = 0; cyc(140);
      expect_val("R7 new event sets irq again", 1); observe(irq);
      hp = 4;

      // ---- R4 lock appearing only after reset ----
      do_reset(3'b110, 1'b0);
      cyc(3); pll_locked = 1'b1; cyc(5);
      expect_val("R4 no acquisition after reset", 0); observe(lock_ok);
      expect_val("R4 late lock treated as loss", 1); observe(fail);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_500_000;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule